// File: doc/BRIEF.md
# Two-Wire Three-State Serial Word Receiver

This block receives a serial stream carried on two single-ended wires, here called `line_p` and `line_n`. The bus has three symbol shapes. With both wires high the bus is resting. A phase with both wires low opens a bit. The wire that then rises first, while its partner stays low, gives the bit value. The bit is therefore set by the order of the edges and not by the level at a sampling instant. The receiver oversamples both wires with its own clock and passes each wire through a two-flop synchronizer. A small decoder turns the wire pairs into bit events. A shifter gathers the bits, lowest bit first, into 32-bit words.

Decoding is armed only after the bus has rested long enough to count as idle. Any symbol seen before that point is dropped. A complete word appears on `word_data` with a one-cycle `word_valid` strobe. When the bus rests again after carrying at least one bit, the receiver raises `end_of_txn` for one cycle. If that transaction did not end on a word boundary, `frame_error` is raised in the same cycle and the leftover bits are thrown away. Both-low phases shorter than a set minimum count as glitches and are ignored.

Top module: `tw_symbol_rx`

## Requirements
- R1: After reset, `word_valid`, `end_of_txn` and `frame_error` are 0 and `word_data` is 0. Reset does not produce any pulse.
- R2: Decoding is armed only after both synchronized wires have been high for IDLE_CYCLES consecutive clock samples. Every symbol received before that is ignored and produces no word and no pulse.
- R3: A both-low phase of at least MIN_LOW_CYCLES samples, followed by `line_n` high while `line_p` stays low, decodes as bit value 0.
- R4: A both-low phase of at least MIN_LOW_CYCLES samples, followed by `line_p` high while `line_n` stays low, decodes as bit value 1.
- R5: Bits fill a word starting at bit 0, so the first bit received ends up in `word_data[0]`. On the 32nd bit, `word_valid` is high for exactly one cycle and `word_data` shows the word. `word_data` then holds that value until the next word completes.
- R6: Bits and words may follow each other with no idle between them. A both-high stretch shorter than IDLE_CYCLES neither ends the transaction nor breaks the word being assembled.
- R7: A both-low phase shorter than MIN_LOW_CYCLES is ignored, together with the rise that follows it. It adds no bit.
- R8: `end_of_txn` pulses for one cycle when the wires have been both high for IDLE_CYCLES samples and at least one bit has been decoded since the previous idle. An idle stretch with no bits in it gives no pulse.
- R9: If the bit count at the end of a transaction is not a multiple of 32, `frame_error` pulses in the same cycle as `end_of_txn`. The partial word is discarded, and the next transaction starts again at bit 0.
- R10: `word_valid` and `frame_error` are never high in the same cycle, and `frame_error` is never high without `end_of_txn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_p | input | 1 | Bus wire whose rise signals a 1 |
| line_n | input | 1 | Bus wire whose rise signals a 0 |
| word_data | output | 32 | Last completed word, LSB received first |
| word_valid | output | 1 | One-cycle strobe when a word completes |
| end_of_txn | output | 1 | One-cycle strobe when the bus returns to idle after traffic |
| frame_error | output | 1 | One-cycle strobe when a transaction ends mid-word |

## Verification
Two reports can fall in the same clock cycle: the end-of-transaction strobe and the framing-error strobe. The bench provokes this by stopping after 37 bits and then resting the bus. A monitor sampling on the falling edge counts the cycles in which both strobes are high together, and it must count exactly one such cycle, with no framing error seen on its own. The bench then sends a clean word, which must come out whole, showing that the five leftover bits were dropped. The opposite pairing, a word strobe together with a framing error, must never happen.

// File: rtl/tw_rx_pkg.sv
// Package: shared types for the two-wire receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package tw_rx_pkg;

    // Classification of one synchronized sample of the wire pair.
    typedef enum logic [1:0] {
        LN_BOTH_LOW  = 2'b00,
        LN_N_HIGH    = 2'b01,
        LN_P_HIGH    = 2'b10,
        LN_BOTH_HIGH = 2'b11
    } line_state_e;

    // Map a {p, n} sample onto its line state.
    function automatic line_state_e classify(input logic p, input logic n);
        return line_state_e'({p, n});
    endfunction

endpackage

// File: rtl/tw_sync.sv
// Module: tw_sync
// Brings LINES asynchronous inputs into the clk domain. Each input gets its
// own chain of STAGES flops.
// Assumes: STAGES >= 2. The flops reset to 1, the resting level of the bus.
module tw_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);

    genvar gi;
    generate
        for (gi = 0; gi < LINES; gi++) begin : g_line
            logic [STAGES-1:0] chain;

            // Shift the raw level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[gi]};
                end
            end

            assign sync_out[gi] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tw_decoder.sv
// Module: tw_decoder
// Turns synchronized wire samples into bit events and idle events.
// A both-low run of at least MIN_LOW_CYCLES samples followed by exactly one
// wire high gives one bit, whose value is the level of p. Decoding stays
// disarmed until the first both-high run of IDLE_CYCLES samples. idle_evt
// fires once per such run, and only when a bit was decoded since the last one.
// Assumes: IDLE_CYCLES >= 2, MIN_LOW_CYCLES >= 1.
module tw_decoder
    import tw_rx_pkg::*;
#(
    parameter int IDLE_CYCLES    = 16,
    parameter int MIN_LOW_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic p,
    input  logic n,
    output logic bit_valid,
    output logic bit_value,
    output logic idle_evt
);

    localparam int HW = $clog2(IDLE_CYCLES + 1);
    localparam int LW = $clog2(MIN_LOW_CYCLES + 1);
    localparam logic [HW-1:0] HI_LAST = HW'(IDLE_CYCLES - 1);
    localparam logic [HW-1:0] HI_SAT  = HW'(IDLE_CYCLES);
    localparam logic [LW-1:0] LO_SAT  = LW'(MIN_LOW_CYCLES);

    line_state_e   ls;
    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;
    logic          armed;
    logic          busy;
    logic          decode;
    logic          idle_hit;

    // Classify the current sample and form the event conditions.
    always_comb begin
        ls       = classify(p, n);
        decode   = armed && (lo_cnt == LO_SAT) &&
                   (ls == LN_P_HIGH || ls == LN_N_HIGH);
        idle_hit = (ls == LN_BOTH_HIGH) && (hi_cnt == HI_LAST);
    end

    // Count consecutive both-high samples, saturating at IDLE_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (ls != LN_BOTH_HIGH) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_SAT) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // Count consecutive both-low samples, saturating at MIN_LOW_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
        end else if (ls != LN_BOTH_LOW) begin
            lo_cnt <= '0;
        end else if (lo_cnt != LO_SAT) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // Arm once idle is seen, and track traffic since the last idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            busy  <= 1'b0;
        end else begin
            armed <= armed | idle_hit;
            if (idle_hit) begin
                busy <= 1'b0;
            end else if (decode) begin
                busy <= 1'b1;
            end
        end
    end

    // Register the bit and idle events for the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_value <= 1'b0;
            idle_evt  <= 1'b0;
        end else begin
            bit_valid <= decode;
            bit_value <= p;
            idle_evt  <= idle_hit && busy;
        end
    end

endmodule

// File: rtl/tw_shifter.sv
// Module: tw_shifter
// Collects bits LSB-first into WORD_BITS-wide words. It presents each finished
// word with a one-cycle strobe. When an idle event arrives, it reports the end
// of the transaction, flags a partial word and drops it.
// Assumes: bit_valid and idle_evt are never high together (the decoder needs
// different wire states for them).
module tw_shifter #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_valid,
    input  logic                 bit_value,
    input  logic                 idle_evt,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_valid,
    output logic                 end_of_txn,
    output logic                 frame_error
);

    localparam int CW = $clog2(WORD_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(WORD_BITS - 1);

    logic [WORD_BITS-1:0] shreg;
    logic [WORD_BITS-1:0] shreg_next;
    logic [CW-1:0]        bit_cnt;

    // New bits enter at the top, so the first bit ends up at bit 0.
    always_comb begin
        shreg_next = {bit_value, shreg[WORD_BITS-1:1]};
    end

    // Shift register and bit counter; an idle event clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (idle_evt) begin
            bit_cnt <= '0;
        end else if (bit_valid) begin
            shreg   <= shreg_next;
            bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Present finished words and the end-of-transaction reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_data   <= '0;
            word_valid  <= 1'b0;
            end_of_txn  <= 1'b0;
            frame_error <= 1'b0;
        end else begin
            word_valid  <= bit_valid && (bit_cnt == CNT_LAST);
            end_of_txn  <= idle_evt;
            frame_error <= idle_evt && (bit_cnt != '0);
            if (bit_valid && (bit_cnt == CNT_LAST)) begin
                word_data <= shreg_next;
            end
        end
    end

endmodule

// File: rtl/tw_symbol_rx.sv
// Module: tw_symbol_rx (top)
// Two-wire three-state serial receiver: synchronizer, symbol decoder and
// word shifter connected in a chain.
// Assumes: clk is fast enough that every bus phase spans several samples.
module tw_symbol_rx #(
    parameter int WORD_BITS      = 32,
    parameter int SYNC_STAGES    = 2,
    parameter int IDLE_CYCLES    = 16,
    parameter int MIN_LOW_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_p,
    input  logic                 line_n,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_valid,
    output logic                 end_of_txn,
    output logic                 frame_error
);

    logic [1:0] raw_lines;
    logic [1:0] sync_lines;
    logic       bit_valid;
    logic       bit_value;
    logic       idle_evt;

    assign raw_lines = {line_p, line_n};

    tw_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    tw_decoder #(
        .IDLE_CYCLES    (IDLE_CYCLES),
        .MIN_LOW_CYCLES (MIN_LOW_CYCLES)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .p         (sync_lines[1]),
        .n         (sync_lines[0]),
        .bit_valid (bit_valid),
        .bit_value (bit_value),
        .idle_evt  (idle_evt)
    );

    tw_shifter #(
        .WORD_BITS (WORD_BITS)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .idle_evt    (idle_evt),
        .word_data   (word_data),
        .word_valid  (word_valid),
        .end_of_txn  (end_of_txn),
        .frame_error (frame_error)
    );

endmodule

// File: rtl/tw_symbol_rx_chk.sv
// Module: tw_symbol_rx_chk
// Property checker for the receiver's output strobes, bound to the top.
module tw_symbol_rx_chk #(
    parameter int WORD_BITS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [WORD_BITS-1:0] word_data,
    input logic                 word_valid,
    input logic                 end_of_txn,
    input logic                 frame_error
);

    // R10: a finished word and a framing error never share a cycle.
    p_word_not_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && frame_error));

    // R9: a framing error is always reported together with end of transaction.
    p_err_with_eot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> end_of_txn);

    // R8: the end-of-transaction strobe lasts one cycle.
    p_eot_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_txn |=> !end_of_txn);

    // R5: the word strobe lasts one cycle.
    p_word_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R5: the word output changes only on a word strobe.
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> (word_valid || $stable(word_data)));

    // R8: a transaction cannot end in the cycle right after a word completes.
    p_no_eot_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !end_of_txn);

endmodule

bind tw_symbol_rx tw_symbol_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_data   (word_data),
    .word_valid  (word_valid),
    .end_of_txn  (end_of_txn),
    .frame_error (frame_error)
);

// File: tb/test_tw_symbol_rx.sv
// Directed bench for tw_symbol_rx. Each task drives one scenario and checks it.
module test_tw_symbol_rx;

    localparam int LOWC  = 6;   // both-low cycles of a real symbol
    localparam int HIGHC = 6;   // one-wire-high cycles of a symbol
    localparam int IDLEC = 30;  // cycles held both high to end a transaction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_p = 1'b1;
    logic        line_n = 1'b1;
    logic [31:0] word_data;
    logic        word_valid;
    logic        end_of_txn;
    logic        frame_error;

    int checks = 0;
    int fails  = 0;

    // Monitor counters.
    int          n_words = 0;
    int          n_eot = 0;
    int          n_fe = 0;
    int          n_both = 0;
    int          n_fe_alone = 0;
    logic [31:0] words [0:7];

    always #4 clk = ~clk;   // 125 MHz

    tw_symbol_rx i_tw_symbol_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_p      (line_p),
        .line_n      (line_n),
        .word_data   (word_data),
        .word_valid  (word_valid),
        .end_of_txn  (end_of_txn),
        .frame_error (frame_error)
    );

    // Record strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                words[n_words % 8] = word_data;
                n_words++;
            end
            if (end_of_txn) n_eot++;
            if (frame_error) n_fe++;
            if (frame_error && end_of_txn) n_both++;
            if (frame_error && !end_of_txn) n_fe_alone++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst_n  = 1'b0;
        line_p = lvl;
        line_n = lvl;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        line_p = 1'b0; line_n = 1'b0;
        repeat (LOWC) @(negedge clk);
        line_p = b; line_n = ~b;
        repeat (HIGHC - 1) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int nb);
        for (int i = 0; i < nb; i++) send_bit(w[i]);
    endtask

    task automatic go_idle(input int cyc);
        @(negedge clk);
        line_p = 1'b1; line_n = 1'b1;
        repeat (cyc) @(negedge clk);
    endtask

    // R1: quiet outputs after reset.
    task automatic t_reset;
        do_reset(1'b1);
        check(word_valid == 1'b0 && end_of_txn == 1'b0 && frame_error == 1'b0,
              "R1 strobes low after reset", {29'd0, word_valid, end_of_txn, frame_error}, 32'd0);
        check(word_data == 32'd0, "R1 word_data after reset", word_data, 32'd0);
        go_idle(IDLEC);
        check(n_eot == 0, "R8 no eot for reset idle", n_eot, 0);
    endtask

    // R2: symbols before the first idle are dropped.
    task automatic t_prearm;
        int w0, e0;
        do_reset(1'b0);
        w0 = n_words; e0 = n_eot;
        send_bits(32'h1234_5678, 32);
        go_idle(IDLEC);
        check(n_words == w0, "R2 no word before arming", n_words - w0, 0);
        check(n_eot == e0, "R2 no eot before arming", n_eot - e0, 0);
    endtask

    // R3 R4 R5 R8: one clean word.
    task automatic t_single;
        int w0, e0, f0;
        w0 = n_words; e0 = n_eot; f0 = n_fe;
        send_bits(32'hA5C3_0F96, 32);
        check(n_words == w0 + 1, "R5 one word strobe", n_words - w0, 1);
        check(words[w0 % 8] == 32'hA5C3_0F96, "R3 R4 R5 word value LSB first",
              words[w0 % 8], 32'hA5C3_0F96);
        go_idle(IDLEC);
        check(n_eot == e0 + 1, "R8 one eot", n_eot - e0, 1);
        check(n_fe == f0, "R9 no frame error on boundary", n_fe - f0, 0);
        check(word_data == 32'hA5C3_0F96, "R5 word held", word_data, 32'hA5C3_0F96);
    endtask

    // R6: two words back to back.
    task automatic t_back2back;
        int w0, e0;
        w0 = n_words; e0 = n_eot;
        send_bits(32'h0000_0001, 32);
        send_bits(32'hFFFF_FFFE, 32);
        go_idle(IDLEC);
        check(n_words == w0 + 2, "R6 two words", n_words - w0, 2);
        check(words[w0 % 8] == 32'h0000_0001, "R4 R6 first word", words[w0 % 8], 32'h1);
        check(words[(w0 + 1) % 8] == 32'hFFFF_FFFE, "R3 R6 second word",
              words[(w0 + 1) % 8], 32'hFFFF_FFFE);
        check(n_eot == e0 + 1, "R8 single eot for two words", n_eot - e0, 1);
    endtask

    // R9 R10: partial word, eot and frame error together, then clean restart.
    task automatic t_partial;
        int w0, e0, f0, b0, a0;
        w0 = n_words; e0 = n_eot; f0 = n_fe; b0 = n_both; a0 = n_fe_alone;
        send_bits(32'h0F0F_3C3C, 32);
        send_bits(32'h0000_001F, 5);
        go_idle(IDLEC);
        check(n_words == w0 + 1, "R9 only full word out", n_words - w0, 1);
        check(n_both == b0 + 1, "R9 frame error with eot", n_both - b0, 1);
        check(n_fe_alone == a0, "R10 no lone frame error", n_fe_alone - a0, 0);
        check(n_eot == e0 + 1 && n_fe == f0 + 1, "R9 counts", n_fe - f0, 1);
        send_bits(32'h8000_0000, 32);
        go_idle(IDLEC);
        check(words[(w0 + 1) % 8] == 32'h8000_0000, "R9 partial discarded",
              words[(w0 + 1) % 8], 32'h8000_0000);
    endtask

    // R7: short low phases add no bit.
    task automatic t_glitch;
        int w0;
        w0 = n_words;
        send_bits(32'h0000_5A5A, 16);
        @(negedge clk);
        line_p = 1'b0; line_n = 1'b0;
        repeat (2) @(negedge clk);
        line_p = 1'b1; line_n = 1'b0;
        repeat (HIGHC) @(negedge clk);
        send_bits(32'h0000_C33C, 16);
        go_idle(IDLEC);
        check(n_words == w0 + 1, "R7 glitch adds no bit", n_words - w0, 1);
        check(words[w0 % 8] == 32'hC33C_5A5A, "R7 word intact", words[w0 % 8], 32'hC33C_5A5A);
    endtask

    // R6: a short both-high gap does not end the transaction.
    task automatic t_short_gap;
        int w0, e0, f0;
        w0 = n_words; e0 = n_eot; f0 = n_fe;
        send_bits(32'h0000_BEEF, 16);
        go_idle(8);
        send_bits(32'h0000_DEAD, 16);
        go_idle(IDLEC);
        check(n_words == w0 + 1 && words[w0 % 8] == 32'hDEAD_BEEF, "R6 gap keeps word",
              words[w0 % 8], 32'hDEAD_BEEF);
        check(n_eot == e0 + 1 && n_fe == f0, "R6 gap no early eot", n_eot - e0, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_prearm();
        t_single();
        t_back2back();
        t_partial();
        t_glitch();
        t_short_gap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule